// File: doc/BRIEF.md
# Multi-Format Serial Audio Frame Transmitter

This block is the transmit half of a serial audio port that runs as clock master. A single clock-enable strobe marks each bit-clock period. On each strobe the block advances one bit position through a frame. It drives the frame clock and the serial data line, and takes samples from an internal FIFO that a DMA engine keeps filled. The strobe must be at least two system clocks apart. Each bit position is presented on `sdout` and `lrck` from the second system clock edge after the strobe edge that starts it.

One framing engine covers five wire formats. `cfg_fmt` selects half-frame framing (1 = left-aligned, 2 = right-aligned) or whole-frame PCM framing (0). `cfg_offset` delays data by one bit clock after each segment start. The combinations are: standard I2S = 1 with offset 1; left-justified = 1 with offset 0; right-justified = 2; PCM long frame = 0 with offset 0; PCM short frame = 0 with offset 1.

`cfg_period` sets the segment length. In half-frame formats it is half the bit clocks per frame minus one. In PCM it is the whole frame minus one. Sample width and slot width use a 3-bit code c, which gives 4c+4 bits (codes 1..7, so 8 to 32 bits). Software brings the port up in this order: flush the FIFO, clear the sample counter, then raise the module, transmit, data-output and request enables.

Top module: `audio_frame_tx`

## Requirements
- R1: While reset is held, and after it is released with all enables low, `sdout`, `lrck`, `drq` and `underrun` are 0 and `tx_count` is 0.
- R2: A width code c gives 4c+4 bits. Samples are sent MSB first. In the aligned formats (`cfg_fmt` 0 or 1), slot bits past the sample width are 0.
- R3: In half-frame formats (`cfg_fmt` 1 or 2), a frame is 2*(`cfg_period`+1) bit clocks. `lrck` is 0 for the first half and 1 for the second, and it is inverted when `cfg_lr_inv` is 1.
- R4: With `cfg_offset`=1, the MSB of the first slot appears one bit clock after each segment start. With `cfg_offset`=0, it appears on the segment's first bit clock.
- R5: With `cfg_fmt`=2, the sample fills the last sample-width bits of its slot, and the leading bits are 0.
- R6: With `cfg_fmt`=0, a frame is `cfg_period`+1 bit clocks and slots follow one another from the data start. With offset 1, `lrck` is a one-bit-clock pulse at frame start. With offset 0, `lrck` is high for the first slot-width bit clocks. Both are inverted by `cfg_lr_inv`.
- R7: Slot numbering: in half-frame formats, slot 2k is the k-th slot of the first half and slot 2k+1 is the k-th slot of the second half. In PCM, slot k is the k-th slot of the frame. A slot whose number is at least `cfg_slot_cnt`, or whose bit in `cfg_slot_en` is 0, sends zeros and takes no FIFO entry.
- R8: If the FIFO is empty when a live slot starts, that slot sends zeros and `underrun` is set. `underrun` stays set until a FIFO flush clears it.
- R9: `drq` is registered. It is high one clock after the FIFO holds fewer than DEPTH/2 entries while `en_module` and `en_drq` are both 1. Otherwise it is low.
- R10: A flush empties the FIFO, and a write in the same cycle is dropped. A write to a full FIFO is dropped, and the entries already stored are sent in order.
- R11: `tx_count` increments once for each live slot started, underrun slots included. `cnt_clr` sets it to 0.
- R12: With `en_dout`=0, `sdout` is 0 while framing, `lrck` and FIFO consumption continue.
- R13: With `en_module`=0, framing is idle, `sdout` is 0 and `drq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | One-cycle strobe per bit clock |
| cfg_fmt | input | 2 | 0 PCM, 1 left-aligned, 2 right-aligned |
| cfg_offset | input | 1 | One-bit data delay after segment start |
| cfg_period | input | PER_W | Segment length minus one |
| cfg_sw_code | input | 3 | Sample width code |
| cfg_slotw_code | input | 3 | Slot width code |
| cfg_slot_cnt | input | $clog2(SLOTS+1) | Number of slots in use |
| cfg_slot_en | input | SLOTS | Per-slot transmit enables |
| cfg_lr_inv | input | 1 | Frame clock inversion |
| en_module | input | 1 | Module enable |
| en_tx | input | 1 | Transmit path enable |
| en_dout | input | 1 | Data line enable |
| en_drq | input | 1 | DMA request enable |
| fifo_flush | input | 1 | Empty the FIFO, clear underrun |
| cnt_clr | input | 1 | Clear the sample counter |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | DW | FIFO write data |
| sdout | output | 1 | Serial data, registered |
| lrck | output | 1 | Frame clock, registered |
| drq | output | 1 | DMA request, registered |
| underrun | output | 1 | Sticky empty-FIFO flag |
| tx_count | output | TXC_W | Slots serviced since clear |

## Verification
The assertions take the configuration as static while `en_tx` and `en_module` are both high. The segment-length check in particular holds only if `cfg_period` does not shrink under a running counter. They also take the sample width to be no wider than the slot, and the strobe to be at least two clocks apart. The stimulus changes every configuration field only after dropping `en_tx` and waiting a clock. It always uses sample widths that fit the slot, and it spaces strobes four clocks apart. Against these conditions, a reference model built from the requirements predicts every bit-clock value of `sdout` and `lrck`.

// File: rtl/aft_pkg.sv
package aft_pkg;
  typedef enum logic [1:0] {
    FMT_PCM   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_e;

  // width code c selects 4c+4 bits
  function automatic logic [5:0] code_to_bits(input logic [2:0] code);
    return {1'b0, code, 2'b00} + 6'd4;
  endfunction
endpackage

// File: rtl/aft_fifo.sv
module aft_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic             pop,
  output logic [DW-1:0]    rdata,
  output logic [LVL_W-1:0] level,
  output logic             empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  assign empty = (level == '0);
  assign do_wr = wr && !flush && (level != LVL_W'(DEPTH));
  assign do_rd = pop && !flush && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (pop) begin
      rdata <= empty ? '0 : mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> level == '0);
endmodule

// File: rtl/aft_frame_seq.sv
module aft_frame_seq #(
  parameter int PER_W = 9,
  parameter int SLOTS = 8,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int G_W   = PER_W + 1,
  localparam int SI_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step,
  input  logic [1:0]       cfg_fmt,
  input  logic             cfg_offset,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [5:0]       slotw,
  input  logic [CNT_W-1:0] cfg_slot_cnt,
  input  logic [SLOTS-1:0] cfg_slot_en,
  input  logic             cfg_lr_inv,
  output logic             live_o,
  output logic [5:0]       sbit_o,
  output logic             lr_o,
  output logic             pop_o
);
  import aft_pkg::*;

  logic             started, half, inreg;
  logic [PER_W-1:0] seg, sk;
  logic [5:0]       sbit;
  logic             n_half, n_in;
  logic [PER_W-1:0] n_seg, n_k;
  logic [5:0]       n_bit;
  logic             halves;
  logic [G_W-1:0]   cur_g, nxt_g;
  logic             lr_raw;

  assign halves = (fmt_e'(cfg_fmt) != FMT_PCM);

  function automatic logic live_of(input logic [G_W-1:0] g);
    return (g < G_W'(cfg_slot_cnt)) && (g < G_W'(SLOTS)) && cfg_slot_en[g[SI_W-1:0]];
  endfunction

  always_comb begin
    n_seg  = seg;
    n_half = half;
    n_in   = inreg;
    n_bit  = sbit;
    n_k    = sk;
    if (!started || seg == cfg_period) begin
      n_seg  = '0;
      n_half = started && halves && !half;
      n_in   = !cfg_offset;
      n_bit  = '0;
      n_k    = '0;
    end else begin
      n_seg = seg + 1'b1;
      if (!inreg) begin
        n_in  = 1'b1;
        n_bit = '0;
        n_k   = '0;
      end else if (sbit == slotw - 6'd1) begin
        n_bit = '0;
        n_k   = sk + 1'b1;
      end else begin
        n_bit = sbit + 6'd1;
      end
    end
  end

  assign cur_g  = halves ? {sk, half} : {1'b0, sk};
  assign nxt_g  = halves ? {n_k, n_half} : {1'b0, n_k};
  assign pop_o  = run && step && n_in && (n_bit == '0) && live_of(nxt_g);
  assign live_o = started && inreg && live_of(cur_g);
  assign sbit_o = sbit;

  always_comb begin
    if (!started)        lr_raw = 1'b0;
    else if (halves)     lr_raw = half;
    else if (cfg_offset) lr_raw = (seg == '0);
    else                 lr_raw = (seg < PER_W'(slotw));
  end
  assign lr_o = lr_raw ^ cfg_lr_inv;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      started <= 1'b0;
      seg     <= '0;
      half    <= 1'b0;
      inreg   <= 1'b0;
      sbit    <= '0;
      sk      <= '0;
    end else if (step) begin
      started <= 1'b1;
      seg     <= n_seg;
      half    <= n_half;
      inreg   <= n_in;
      sbit    <= n_bit;
      sk      <= n_k;
    end
  end

  assert_seg_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    started |-> seg <= cfg_period);
  assert_idle_when_stopped_R13: assert property (@(posedge clk) disable iff (rst)
    !run |=> !started);
endmodule

// File: rtl/aft_bit_out.sv
module aft_bit_out #(
  parameter int DW = 32,
  localparam int IX_W = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          live,
  input  logic [5:0]    sbit,
  input  logic [5:0]    sw,
  input  logic [5:0]    slotw,
  input  logic          right,
  input  logic          dout_en,
  input  logic          lr_in,
  input  logic [DW-1:0] sample,
  output logic          sdout,
  output logic          lrck
);
  logic [5:0]      lead, rel;
  logic [IX_W-1:0] idx;
  logic            bit_v;

  always_comb begin
    lead  = (right && slotw > sw) ? slotw - sw : 6'd0;
    rel   = sbit - lead;
    idx   = IX_W'(sw - 6'd1 - rel);
    bit_v = live && (sbit >= lead) && (rel < sw) && sample[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdout <= 1'b0;
      lrck  <= 1'b0;
    end else begin
      sdout <= bit_v && dout_en;
      lrck  <= lr_in;
    end
  end

  assert_quiet_data_R12: assert property (@(posedge clk) disable iff (rst)
    !dout_en |=> !sdout);
endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int PER_W = 9,
  parameter int SLOTS = 8,
  parameter int TXC_W = 16,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int HALF  = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_en,
  input  logic [1:0]       cfg_fmt,
  input  logic             cfg_offset,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [2:0]       cfg_sw_code,
  input  logic [2:0]       cfg_slotw_code,
  input  logic [CNT_W-1:0] cfg_slot_cnt,
  input  logic [SLOTS-1:0] cfg_slot_en,
  input  logic             cfg_lr_inv,
  input  logic             en_module,
  input  logic             en_tx,
  input  logic             en_dout,
  input  logic             en_drq,
  input  logic             fifo_flush,
  input  logic             cnt_clr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic             sdout,
  output logic             lrck,
  output logic             drq,
  output logic             underrun,
  output logic [TXC_W-1:0] tx_count
);
  import aft_pkg::*;

  logic             run, pop, empty, live, lr_c;
  logic [5:0]       sw, slotw, sbit;
  logic [DW-1:0]    sample;
  logic [LVL_W-1:0] level;

  assign run   = en_module && en_tx;
  assign sw    = code_to_bits(cfg_sw_code);
  assign slotw = code_to_bits(cfg_slotw_code);

  aft_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(fifo_flush), .wr(wr_en), .wdata(wr_data),
    .pop(pop), .rdata(sample), .level(level), .empty(empty)
  );

  aft_frame_seq #(.PER_W(PER_W), .SLOTS(SLOTS)) u_seq (
    .clk(clk), .rst(rst), .run(run), .step(bclk_en), .cfg_fmt(cfg_fmt),
    .cfg_offset(cfg_offset), .cfg_period(cfg_period), .slotw(slotw),
    .cfg_slot_cnt(cfg_slot_cnt), .cfg_slot_en(cfg_slot_en),
    .cfg_lr_inv(cfg_lr_inv), .live_o(live), .sbit_o(sbit), .lr_o(lr_c),
    .pop_o(pop)
  );

  aft_bit_out #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .live(live), .sbit(sbit), .sw(sw), .slotw(slotw),
    .right(fmt_e'(cfg_fmt) == FMT_RIGHT), .dout_en(en_dout), .lr_in(lr_c),
    .sample(sample), .sdout(sdout), .lrck(lrck)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drq      <= 1'b0;
      underrun <= 1'b0;
      tx_count <= '0;
    end else begin
      drq <= en_module && en_drq && (level < LVL_W'(HALF));
      if (fifo_flush)       underrun <= 1'b0;
      else if (pop && empty) underrun <= 1'b1;
      if (cnt_clr)  tx_count <= '0;
      else if (pop) tx_count <= tx_count + 1'b1;
    end
  end

  assert_count_clear_R11: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> tx_count == '0);
  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    underrun && !fifo_flush |=> underrun);
  assert_drq_off_R13: assert property (@(posedge clk) disable iff (rst)
    !en_module |=> !drq);
endmodule

// File: tb/tb_audio_frame_tx.sv
module tb_audio_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, DEPTH = 16, PER_W = 9, SLOTS = 8, TXC_W = 16;

  logic clk = 1'b0, rst = 1'b1, bclk_en = 1'b0;
  logic [1:0] cfg_fmt = '0;
  logic cfg_offset = 1'b0;
  logic [PER_W-1:0] cfg_period = '0;
  logic [2:0] cfg_sw_code = 3'd1, cfg_slotw_code = 3'd1;
  logic [3:0] cfg_slot_cnt = '0;
  logic [SLOTS-1:0] cfg_slot_en = '0;
  logic cfg_lr_inv = 1'b0;
  logic en_module = 1'b0, en_tx = 1'b0, en_dout = 1'b0, en_drq = 1'b0;
  logic fifo_flush = 1'b0, cnt_clr = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic sdout, lrck, drq, underrun;
  logic [TXC_W-1:0] tx_count;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] mq[$];
  bit m_under = 0;
  int m_cnt = 0;
  bit exp_sd[$];
  bit exp_lr[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_frame_tx #(.DW(DW), .DEPTH(DEPTH), .PER_W(PER_W), .SLOTS(SLOTS), .TXC_W(TXC_W)) dut (
    .clk(clk), .rst(rst), .bclk_en(bclk_en), .cfg_fmt(cfg_fmt), .cfg_offset(cfg_offset),
    .cfg_period(cfg_period), .cfg_sw_code(cfg_sw_code), .cfg_slotw_code(cfg_slotw_code),
    .cfg_slot_cnt(cfg_slot_cnt), .cfg_slot_en(cfg_slot_en), .cfg_lr_inv(cfg_lr_inv),
    .en_module(en_module), .en_tx(en_tx), .en_dout(en_dout), .en_drq(en_drq),
    .fifo_flush(fifo_flush), .cnt_clr(cnt_clr), .wr_en(wr_en), .wr_data(wr_data),
    .sdout(sdout), .lrck(lrck), .drq(drq), .underrun(underrun), .tx_count(tx_count)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_sample(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    if (mq.size() < DEPTH) mq.push_back(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); fifo_flush = 1'b1;
    @(negedge clk); fifo_flush = 1'b0;
    mq.delete(); m_under = 0;
  endtask

  task automatic tick();
    @(negedge clk); bclk_en = 1'b1;
    @(negedge clk); bclk_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pop the scoreboard entry for this bit clock and compare
  task automatic monitor_step(input string req);
    bit es, el;
    es = exp_sd.pop_front();
    el = exp_lr.pop_front();
    check(req, "sdout", {31'd0, sdout}, {31'd0, es});
    check(req, "lrck", {31'd0, lrck}, {31'd0, el});
  endtask

  task automatic set_cfg(input int fmt, input int off, input int per, input int swc,
                         input int slc, input int cnt, input int en, input bit inv);
    cfg_fmt = 2'(fmt); cfg_offset = 1'(off); cfg_period = PER_W'(per);
    cfg_sw_code = 3'(swc); cfg_slotw_code = 3'(slc); cfg_slot_cnt = 4'(cnt);
    cfg_slot_en = SLOTS'(en); cfg_lr_inv = inv;
  endtask

  // driver: computes expected bits from the requirements and pushes them
  task automatic run_frames(input int nfr, input string req);
    int seglen, flen, sw, slw, off, lead;
    bit halves;
    logic [31:0] cur;
    seglen = int'(cfg_period) + 1;
    halves = (cfg_fmt != 2'd0);
    flen = halves ? 2 * seglen : seglen;
    sw = 4 * int'(cfg_sw_code) + 4;
    slw = 4 * int'(cfg_slotw_code) + 4;
    off = int'(cfg_offset);
    lead = (cfg_fmt == 2'd2 && slw > sw) ? slw - sw : 0;
    cur = '0;
    @(negedge clk); en_tx = 1'b1;
    for (int f = 0; f < nfr; f++) begin
      for (int pos = 0; pos < flen; pos++) begin
        int sp, hf, d, k, b, g;
        bit lr, sd;
        hf = (halves && pos >= seglen) ? 1 : 0;
        sp = hf ? pos - seglen : pos;
        if (halves) lr = hf[0];
        else if (off == 1) lr = (sp == 0);
        else lr = (sp < slw);
        lr = lr ^ cfg_lr_inv;
        sd = 1'b0;
        if (sp >= off) begin
          d = sp - off; k = d / slw; b = d % slw;
          g = halves ? 2 * k + hf : k;
          if (g < int'(cfg_slot_cnt) && g < SLOTS && cfg_slot_en[g]) begin
            if (b == 0) begin
              if (mq.size() > 0) cur = mq.pop_front();
              else begin cur = '0; m_under = 1; end
              m_cnt++;
            end
            if (b >= lead && (b - lead) < sw) sd = cur[sw - 1 - (b - lead)];
          end
        end
        if (!en_dout) sd = 1'b0;
        exp_sd.push_back(sd);
        exp_lr.push_back(lr);
        tick();
        monitor_step(req);
      end
    end
    @(negedge clk); en_tx = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1", "sdout in reset", {31'd0, sdout}, 0);
    check("R1", "drq in reset", {31'd0, drq}, 0);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1", "sdout", {31'd0, sdout}, 0);
    check("R1", "lrck", {31'd0, lrck}, 0);
    check("R1", "drq", {31'd0, drq}, 0);
    check("R1", "underrun", {31'd0, underrun}, 0);
    check("R1", "tx_count", {16'd0, tx_count}, 0);
    en_module = 1'b1; en_dout = 1'b1;

    // R4 standard I2S: offset 1, 16-bit sample in 24-bit slot
    do_flush();
    set_cfg(1, 1, 23, 3, 5, 2, 8'h03, 0);
    for (int i = 0; i < 4; i++) write_sample(32'hA5C3_1E00 + 32'h1357_9BDF * i);
    run_frames(2, "R4");
    // R3 polarity inverted
    for (int i = 0; i < 2; i++) write_sample(32'h0F0F_3C3C ^ (32'h9E37_79B9 * i));
    set_cfg(1, 1, 23, 3, 5, 2, 8'h03, 1);
    run_frames(1, "R3");
    // R2 left-justified, 20-bit sample in 24-bit slot
    set_cfg(1, 0, 23, 4, 5, 2, 8'h03, 0);
    for (int i = 0; i < 4; i++) write_sample(32'h8765_4321 + 32'h0101_7F11 * i);
    run_frames(2, "R2");
    // R5 right-justified
    set_cfg(2, 0, 23, 3, 5, 2, 8'h03, 0);
    for (int i = 0; i < 4; i++) write_sample(32'h3AB1_C4D5 * (i + 3));
    run_frames(2, "R5");
    // R6 PCM long frame, slot 2 disabled
    set_cfg(0, 0, 63, 2, 3, 4, 8'h0B, 0);
    for (int i = 0; i < 6; i++) write_sample(32'h5A5A_0000 + 32'h0000_3B7 * i + 32'h0C00 * i);
    run_frames(2, "R6");
    // R6 PCM short frame, inverted
    set_cfg(0, 1, 31, 3, 3, 2, 8'h03, 1);
    for (int i = 0; i < 4; i++) write_sample(32'hC0DE_0000 + 32'h1111 * (i + 1));
    run_frames(2, "R6");
    // R7 two slots per half, slot 3 beyond count
    set_cfg(1, 0, 15, 1, 1, 3, 8'hFF, 0);
    for (int i = 0; i < 6; i++) write_sample(32'h0000_00C3 + 32'h0000_0025 * i);
    run_frames(2, "R7");
    check("R7", "fifo drained underrun", {31'd0, underrun}, {31'd0, m_under});
    // R12 data line disabled, framing and consumption continue
    en_dout = 1'b0;
    for (int i = 0; i < 3; i++) write_sample(32'hFFFF_FFFF);
    run_frames(1, "R12");
    en_dout = 1'b1;
    check("R12", "underrun", {31'd0, underrun}, {31'd0, m_under});
    check("R11", "tx_count", {16'd0, tx_count}, 32'(m_cnt & 16'hFFFF));

    // R9 request level
    do_flush();
    en_drq = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9", "drq empty", {31'd0, drq}, 1);
    for (int i = 0; i < 7; i++) write_sample(32'(i));
    @(negedge clk); @(negedge clk);
    check("R9", "drq level 7", {31'd0, drq}, 1);
    write_sample(32'd7);
    @(negedge clk); @(negedge clk);
    check("R9", "drq level 8", {31'd0, drq}, 0);
    do_flush();
    @(negedge clk); @(negedge clk);
    check("R10", "drq after flush", {31'd0, drq}, 1);
    en_drq = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R9", "drq disabled", {31'd0, drq}, 0);

    // R10 overflow, then R8 underrun after the stored entries run out
    for (int i = 0; i < 20; i++) write_sample(32'h11 * (i + 1));
    set_cfg(1, 0, 15, 1, 1, 4, 8'h0F, 0);
    run_frames(5, "R10");
    check("R8", "underrun set", {31'd0, underrun}, 1);
    check("R11", "tx_count", {16'd0, tx_count}, 32'(m_cnt & 16'hFFFF));
    do_flush();
    check("R8", "underrun cleared", {31'd0, underrun}, 0);
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    m_cnt = 0;
    check("R11", "tx_count cleared", {16'd0, tx_count}, 0);

    // R13 module disabled
    en_module = 1'b0; en_drq = 1'b1; en_tx = 1'b1;
    write_sample(32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) tick();
    check("R13", "drq", {31'd0, drq}, 0);
    check("R13", "sdout", {31'd0, sdout}, 0);
    check("R13", "tx_count", {16'd0, tx_count}, 0);
    en_tx = 1'b0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule